// File: doc/BRIEF.md
# Time-Slot Synchronous Transfer Interrupt Controller

This block gives a microcontroller safe windows for reading and writing four data-access registers whose contents move with the time slots of a serial frame. It runs on the data clock (two data clocks per bit clock), follows a frame-sync strobe and counts the slots of the frame. Each channel has a programmed slot. A fixed number of bit-clock periods after that slot closes, the channel raises a transfer flag. Software reads or writes its register and then acknowledges the flag.

The channel's delay select sets the distance from the slot to the flag. If the slot comes around again while the flag is still pending, an overflow flag is raised. Overflow routing is cross-coupled between channels. A channel with an unmasked transfer flag reports only its own overflows. A channel whose transfer flag is masked lends its overflow flag to every other channel. That flag then fires whenever any other channel overflows.

All flags are sticky and are cleared by writing ones. A single request line is the OR of the pending flags that are not masked.

Top module: `ts_sync_irq`

## Requirements
- R1: A high `fsc` sampled on a rising edge restarts the count, so slot 0 begins with the next cycle. Each slot lasts 16 clock cycles (8 bit clocks of 2 data clocks), and the 5-bit slot number wraps from 31 to 0.
- R2: Let `fsc` be sampled at edge E0, and let channel n select slot s. Then `status[n]` first reads 1 after edge E0+16(s+1)+4 when `dps[n]`=0, and after edge E0+16(s+1)+2 when `dps[n]`=1.
- R3: Transfer flag n (`status[n]`, n=0..3) is set only when `inEn[n]`=1 and `stiMask[n]`=0. Setting `outEn[n]` alone never sets it.
- R4: Overflow flag n (`status[4+n]`) is set only when `outEn[n]`=1 and `stovMask[n]`=0. Setting `inEn[n]` alone never sets it.
- R5: A channel overflows when its transfer event recurs while its transfer flag is still pending. The overflow flag of a channel whose own transfer flag is unmasked is set on that same edge, and only by that channel's own overflow.
- R6: The overflow flag of a channel whose transfer flag is masked (`stiMask[n]`=1) is set by an overflow of any other channel. One overflow may set several overflow flags at once.
- R7: When no channel has both `inEn`=1 and `stiMask`=0, no status bit is ever set, whatever the overflow masks are.
- R8: A cycle with `ackWr`=1 clears every status bit whose `ackData` bit is 1 and leaves the other bits unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: `irq` is the OR of the pending transfer flags with `stiMask`=0 and the pending overflow flags with `stovMask`=0. It follows changes to the masks in the same cycle. After reset, `status` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock (twice the bit-clock rate) |
| rstN | input | 1 | Active-low synchronous reset |
| fsc | input | 1 | Frame-sync strobe, restarts the slot count |
| slotSel | input | 20 | Selected slot for each channel, 5 bits per channel, channel 0 in the low bits |
| dps | input | 4 | Delay select for each channel: 0 gives 2 bit clocks, 1 gives 1 bit clock |
| inEn | input | 4 | Input enable for each channel, required for transfer flags |
| outEn | input | 4 | Output enable for each channel, required for overflow flags |
| stiMask | input | 4 | Transfer-flag mask for each channel (1 = masked) |
| stovMask | input | 4 | Overflow-flag mask for each channel (1 = masked) |
| ackWr | input | 1 | Acknowledge write strobe |
| ackData | input | 8 | Write-one-to-clear pattern, in the same layout as status |
| status | output | 8 | [3:0] transfer flags, [7:4] overflow flags |
| irq | output | 1 | Combined interrupt request |

## Verification
If the slot or phase counter is wrong, every transfer flag appears on the wrong edge, off by whole slots or by a few cycles. This shows in the first frame after sync, so the edge-exact checks on two channels with different delays catch it. A fault in the overflow routing shows only one frame later, when a pending flag sees its slot again. Table rows that separate own-channel routing from lent routing expose it at the second occurrence of each event. Errors in the acknowledge path or the request OR show in the same cycle as the write or the mask change.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
  localparam int CH_N         = 4;   // channels
  localparam int SLOT_W       = 5;   // slot number width
  localparam int BCL_PER_SLOT = 8;   // bit clocks per slot
  localparam int DCL_PER_BCL  = 2;   // data clocks per bit clock
  localparam int DLY_SLOW_BCL = 2;   // delay with select = 0
  localparam int DLY_FAST_BCL = 1;   // delay with select = 1

  localparam int SLOT_DCL = BCL_PER_SLOT * DCL_PER_BCL;
  localparam int PH_W     = $clog2(SLOT_DCL);
  localparam int DLY_SLOW = DLY_SLOW_BCL * DCL_PER_BCL;
  localparam int DLY_FAST = DLY_FAST_BCL * DCL_PER_BCL;
  localparam int ST_W     = 2 * CH_N;

  // strobes passed from the control to the datapath
  typedef struct packed {
    logic [CH_N-1:0] hit;      // transfer event instant per channel
    logic [CH_N-1:0] clrSti;   // acknowledge of transfer flags
    logic [CH_N-1:0] clrStov;  // acknowledge of overflow flags
  } ctlStrb_t;
endpackage

// File: rtl/tsi_slot_ctl.sv
`timescale 1ns/1ps
module tsi_slot_ctl
  import tsi_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fsc,
  input  logic [CH_N*SLOT_W-1:0] slotSel,
  input  logic [CH_N-1:0]        dps,
  input  logic                   ackWr,
  input  logic [ST_W-1:0]        ackData,
  output ctlStrb_t               strb
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_DCL - 1);
  localparam logic [PH_W-1:0] PH_FAST = PH_W'(DLY_FAST - 1);
  localparam logic [PH_W-1:0] PH_SLOW = PH_W'(DLY_SLOW - 1);

  logic [PH_W-1:0]   dclCnt;
  logic [SLOT_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (!rstN || fsc) begin
      dclCnt  <= '0;
      slotCnt <= '0;
    end else begin
      dclCnt <= dclCnt + 1'b1;
      if (dclCnt == PH_LAST) slotCnt <= slotCnt + 1'b1;
    end
  end

  // an event falls in the slot after the selected one, at the delayed phase
  for (genvar i = 0; i < CH_N; i++) begin : g_hit
    logic [SLOT_W-1:0] afterSel;
    assign afterSel   = slotSel[i*SLOT_W +: SLOT_W] + 1'b1;
    assign strb.hit[i] = (slotCnt == afterSel) &&
                         (dclCnt == (dps[i] ? PH_FAST : PH_SLOW));
  end

  assign strb.clrSti  = ackData[CH_N-1:0]    & {CH_N{ackWr}};
  assign strb.clrStov = ackData[ST_W-1:CH_N] & {CH_N{ackWr}};

  // R1: sync restarts the count; the slot steps when the phase wraps
  a_r1_frame_restart: assert property (@(posedge clk) disable iff (!rstN)
    fsc |=> (dclCnt == '0) && (slotCnt == '0));
  a_r1_slot_step: assert property (@(posedge clk) disable iff (!rstN)
    (!fsc && dclCnt == PH_LAST) |=> slotCnt == $past(slotCnt) + 1'b1);
endmodule

// File: rtl/tsi_irq_dp.sv
`timescale 1ns/1ps
module tsi_irq_dp
  import tsi_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic [CH_N-1:0] inEn,
  input  logic [CH_N-1:0] outEn,
  input  logic [CH_N-1:0] stiMask,
  input  logic [CH_N-1:0] stovMask,
  output logic [CH_N-1:0] stiSt,
  output logic [CH_N-1:0] stovSt
);
  logic [CH_N-1:0] stiSet;
  logic [CH_N-1:0] ovf;
  logic [CH_N-1:0] stovSet;

  assign stiSet = strb.hit & inEn & ~stiMask;
  assign ovf    = stiSet & stiSt;

  // own routing for unmasked transfer flags, lent routing for masked ones
  for (genvar i = 0; i < CH_N; i++) begin : g_route
    logic [CH_N-1:0] othersMask;
    logic            otherOvf;
    assign othersMask = ~(CH_N'(1) << i);
    assign otherOvf   = |(ovf & othersMask);
    assign stovSet[i] = outEn[i] && !stovMask[i] &&
                        (stiMask[i] ? otherOvf : ovf[i]);

    // R3: a transfer flag rises only with input enabled and unmasked
    a_r3_sti_gate: assert property (@(posedge clk) disable iff (!rstN)
      (stiSt[i] && !$past(stiSt[i])) |-> $past(inEn[i] && !stiMask[i]));
    // R4: an overflow flag rises only with output enabled and unmasked
    a_r4_stov_gate: assert property (@(posedge clk) disable iff (!rstN)
      (stovSt[i] && !$past(stovSt[i])) |-> $past(outEn[i] && !stovMask[i]));
    // R5 / R7: an overflow needs some transfer flag already pending
    a_r5_stov_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
      (stovSt[i] && !$past(stovSt[i])) |-> $past(|stiSt));
    // R8: acknowledge without a competing set leaves the flag clear
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (strb.clrSti[i] && !stiSet[i]) |=> !stiSt[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stiSt  <= '0;
      stovSt <= '0;
    end else begin
      stiSt  <= (stiSt  & ~strb.clrSti)  | stiSet;
      stovSt <= (stovSt & ~strb.clrStov) | stovSet;
    end
  end
endmodule

// File: rtl/ts_sync_irq.sv
`timescale 1ns/1ps
module ts_sync_irq
  import tsi_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fsc,
  input  logic [CH_N*SLOT_W-1:0] slotSel,
  input  logic [CH_N-1:0]        dps,
  input  logic [CH_N-1:0]        inEn,
  input  logic [CH_N-1:0]        outEn,
  input  logic [CH_N-1:0]        stiMask,
  input  logic [CH_N-1:0]        stovMask,
  input  logic                   ackWr,
  input  logic [ST_W-1:0]        ackData,
  output logic [ST_W-1:0]        status,
  output logic                   irq
);
  ctlStrb_t        strb;
  logic [CH_N-1:0] stiSt;
  logic [CH_N-1:0] stovSt;

  tsi_slot_ctl u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .fsc     (fsc),
    .slotSel (slotSel),
    .dps     (dps),
    .ackWr   (ackWr),
    .ackData (ackData),
    .strb    (strb)
  );

  tsi_irq_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .inEn     (inEn),
    .outEn    (outEn),
    .stiMask  (stiMask),
    .stovMask (stovMask),
    .stiSt    (stiSt),
    .stovSt   (stovSt)
  );

  assign status = {stovSt, stiSt};
  assign irq    = |(stiSt & ~stiMask) | |(stovSt & ~stovMask);

  // R9: the request stays low while every status bit is clear
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (status == '0) |-> !irq);
endmodule

// File: tb/ts_sync_irq_bench.sv
`timescale 1ns/1ps
module ts_sync_irq_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fsc = 1'b0;
  logic [19:0] slotSel;
  logic [3:0]  dps, inEn, outEn, stiMask, stovMask;
  logic        ackWr = 1'b0;
  logic [7:0]  ackData = '0;
  logic [7:0]  status;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  ts_sync_irq u_ts_sync_irq (
    .clk(clk), .rstN(rstN), .fsc(fsc), .slotSel(slotSel), .dps(dps),
    .inEn(inEn), .outEn(outEn), .stiMask(stiMask), .stovMask(stovMask),
    .ackWr(ackWr), .ackData(ackData), .status(status), .irq(irq)
  );

  // {inEn, outEn, stiMask, stovMask, expected transfer flags, expected overflow flags}
  // channel slots 2, 5, 9, 12; channel 1 uses the short delay
  localparam logic [23:0] VEC [12] = '{
    {4'b0001, 4'b0001, 4'b1110, 4'b1111, 4'b0001, 4'b0000},  // R3 single channel
    {4'b1111, 4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b0000},  // R7 all transfer masked
    {4'b0011, 4'b0011, 4'b1110, 4'b1101, 4'b0001, 4'b0010},  // R6 lent flag only
    {4'b0011, 4'b0011, 4'b1110, 4'b1100, 4'b0001, 4'b0011},  // R6 own plus lent
    {4'b0011, 4'b0011, 4'b1100, 4'b1100, 4'b0011, 4'b0011},  // R5 both own
    {4'b0011, 4'b0011, 4'b1100, 4'b1101, 4'b0011, 4'b0010},  // R5 own overflow masked
    {4'b0001, 4'b0011, 4'b1100, 4'b1100, 4'b0001, 4'b0001},  // R5 unmasked stays own
    {4'b0111, 4'b0111, 4'b1100, 4'b1000, 4'b0011, 4'b0111},  // R6 one flag from two
    {4'b0001, 4'b0000, 4'b1110, 4'b0000, 4'b0001, 4'b0000},  // R4 output off
    {4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b1111, 4'b1111},  // R5 all on
    {4'b0111, 4'b1000, 4'b1000, 4'b0111, 4'b0111, 4'b1000},  // R6 three lenders
    {4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0000}   // R3 R7 output alone
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; fsc = 1'b0; ackWr = 1'b0; ackData = '0;
    slotSel = {5'd12, 5'd9, 5'd5, 5'd2};
    dps = 4'b0010;
    inEn = '0; outEn = '0; stiMask = '1; stovMask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // leaves time 2 ns after the edge E0 that samples the strobe
  task automatic syncFrame();
    @(negedge clk);
    fsc = 1'b1;
    @(posedge clk);
    #2;
    fsc = 1'b0;
  endtask

  task automatic ack(input logic [7:0] pat);
    @(negedge clk);
    ackWr = 1'b1; ackData = pat;
    @(posedge clk);
    #2;
    ackWr = 1'b0; ackData = '0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    #1;
    chk("R9 reset status", status, 8'h00);
    chk("R9 reset irq", {7'd0, irq}, 8'h00);

    // edge-exact timing, overflow instant, acknowledge and masking
    @(negedge clk);
    inEn = 4'b0011; outEn = 4'b0011; stiMask = 4'b1100; stovMask = 4'b1100;
    waitEdges(37);                       // run mid-slot before sync (R1)
    syncFrame();
    waitEdges(51);                       // E0+51
    chk("R2 ch0 slow before", {7'd0, status[0]}, 8'h00);
    waitEdges(1);                        // E0+52
    chk("R2 ch0 slow at", {7'd0, status[0]}, 8'h01);
    chk("R9 irq pending", {7'd0, irq}, 8'h01);
    waitEdges(45);                       // E0+97
    chk("R2 ch1 fast before", {7'd0, status[1]}, 8'h00);
    waitEdges(1);                        // E0+98
    chk("R2 ch1 fast at", {7'd0, status[1]}, 8'h01);
    waitEdges(465);                      // E0+563
    chk("R5 overflow before", {7'd0, status[4]}, 8'h00);
    waitEdges(1);                        // E0+564
    chk("R5 overflow at", {7'd0, status[4]}, 8'h01);
    ack(8'h01);
    chk("R8 partial ack", status, 8'h12);
    ack(8'h00);
    chk("R8 zero ack", status, 8'h12);
    @(negedge clk);
    stiMask = 4'b1110; stovMask = 4'b1101;
    #1;
    chk("R9 masks hide pending", {7'd0, irq}, 8'h00);
    chk("R9 status raw", status, 8'h12);

    // set beats clear in the same cycle
    doReset();
    @(negedge clk);
    inEn = 4'b0001; stiMask = 4'b1110;
    waitEdges(300);
    syncFrame();
    waitEdges(51);
    ack(8'h01);                          // clear lands on edge E0+52
    chk("R8 set wins", {7'd0, status[0]}, 8'h01);

    // vector table
    for (int v = 0; v < 12; v++) begin
      logic [23:0] e;
      e = VEC[v];
      doReset();
      @(negedge clk);
      inEn = e[23:20]; outEn = e[19:16]; stiMask = e[15:12]; stovMask = e[11:8];
      syncFrame();
      waitEdges(1100);
      chk($sformatf("R3 R6 R7 row%0d transfer", v), {4'd0, status[3:0]}, {4'd0, e[7:4]});
      chk($sformatf("R4 R5 R6 row%0d overflow", v), {4'd0, status[7:4]}, {4'd0, e[3:0]});
      chk($sformatf("R9 row%0d irq", v), {7'd0, irq}, {7'd0, (e[7:0] != 8'h00)});
      ack(8'hFF);
      chk($sformatf("R8 row%0d ack all", v), status, 8'h00);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule